// File: doc/BRIEF.md
# Banked Program Counter Sequencer

This block produces the program fetch address for a small 4-bit processor whose 8 KB program space is divided into two 4 KB halves. It keeps a 12-bit counter that only ever addresses inside the active half, plus a separate bank bit that selects which half is fetched. The fetch address is the bank bit placed above the counter.

Decoded strobes from the instruction decoder drive the counter. A sequential advance steps it by the length of the current instruction, which is one or two bytes. A taken conditional branch rewrites only the low byte, so it stays inside its 256-byte page. A jump or call loads a full 12-bit target, and a return loads a 12-bit value popped from an external stack. Bank commands do not move the fetch stream straight away. The requested bank is held as pending and becomes active at the next jump, call or return.

The current counter is also driven out so that an external stack can save it on a call. Condition evaluation, the stack, the decoder and the memories all sit outside this block.

Top module: `banked_pc_seq`

## Requirements
- R1: While reset is asserted, and in the first cycle after it is released, the counter, the active bank and the pending bank are all 0, so `fetch_addr_o` reads 0.
- R2: A sequential advance (`adv_i`) adds 1 to the counter when `len2_i` is 0 and 2 when `len2_i` is 1, modulo 4096. A wrap past 0xFFF leaves the bank bit unchanged.
- R3: A taken branch (`br_i` and `br_taken_i` both 1) sets the counter to {bits 11:8 of (counter + instruction length), `br_tgt_i`}. The page therefore comes from the byte after the branch instruction.
- R4: A branch that is not taken has no effect of its own. The counter holds if `adv_i` is 0 and advances as in R2 if `adv_i` is 1.
- R5: A jump or call (`jmp_i`) loads `jmp_tgt_i` into all 12 counter bits.
- R6: A return (`ret_i`) loads `ret_val_i` into all 12 counter bits.
- R7: When several strobes are present in one cycle, the counter follows only the highest: return, then jump, then taken branch, then sequential advance.
- R8: A bank command (`bsel_i`) records `bsel_val_i` as the pending bank (0 selects the lower half, 1 the upper). Advances and branches never change the active bank.
- R9: A jump or a return copies the pending bank into the active bank. If a bank command arrives in the same cycle, its value is the one that becomes active.
- R10: `fetch_addr_o` is {active bank, counter}, with the bank in bit 12, and `pc_o` equals the counter.
- R11: In a cycle with no advance, no taken branch, no jump and no return, the counter and the active bank hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| adv_i | input | 1 | Sequential advance strobe |
| len2_i | input | 1 | Current instruction is two bytes long |
| br_i | input | 1 | Conditional branch strobe |
| br_taken_i | input | 1 | Branch condition is true |
| br_tgt_i | input | 8 | Branch target, low byte |
| jmp_i | input | 1 | Jump or call strobe |
| jmp_tgt_i | input | 12 | Jump or call target |
| ret_i | input | 1 | Return strobe |
| ret_val_i | input | 12 | Return address from the stack |
| bsel_i | input | 1 | Bank command strobe |
| bsel_val_i | input | 1 | Bank requested by the command |
| fetch_addr_o | output | 13 | Program fetch address |
| pc_o | output | 12 | Current counter, for pushing on a call |

## Verification
Two kinds of overlap matter here. The first is a counter load arriving together with other counter strobes: a return or jump alongside a taken branch and an advance, or a taken branch alongside an advance. The second is a bank command landing in the same cycle as the jump or return that commits it. The bench drives these combinations directly, then adds a long stretch of random strobes in which overlaps occur often. A behavioural model, applying the priority and bank rules with plain integers, predicts the fetch address and the counter, and both are compared after every clock edge.

// File: rtl/pcs_pkg.sv
package pcs_pkg;

  typedef enum logic [2:0] {
    SRC_HOLD = 3'd0,
    SRC_SEQ  = 3'd1,
    SRC_BR   = 3'd2,
    SRC_JMP  = 3'd3,
    SRC_RET  = 3'd4
  } pc_src_e;

  // Byte distance to the next instruction.
  function automatic logic [1:0] instr_len(input logic two_byte);
    return two_byte ? 2'd2 : 2'd1;
  endfunction

  // Address of the byte after the current instruction, wrapped to w bits.
  function automatic logic [31:0] step_addr(input logic [31:0] pc,
                                            input logic two_byte,
                                            input int unsigned w);
    logic [31:0] mask;
    mask = (32'd1 << w) - 32'd1;
    return (pc + 32'(instr_len(two_byte))) & mask;
  endfunction

  // Keep the page bits of seq, replace the low pw bits with tgt.
  function automatic logic [31:0] page_join(input logic [31:0] seq,
                                            input logic [31:0] tgt,
                                            input int unsigned pw);
    logic [31:0] lo_mask;
    lo_mask = (32'd1 << pw) - 32'd1;
    return (seq & ~lo_mask) | (tgt & lo_mask);
  endfunction

endpackage

// File: rtl/pcs_next_sel.sv
module pcs_next_sel
  import pcs_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  logic    adv_i,
  input  logic    br_i,
  input  logic    br_taken_i,
  input  logic    jmp_i,
  input  logic    ret_i,
  output pc_src_e src_o,
  output logic    commit_o
);

  // Named events, one per winning source.
  logic ev_ret, ev_jmp, ev_br, ev_seq;

  assign ev_ret = ret_i;
  assign ev_jmp = jmp_i & ~ret_i;
  assign ev_br  = br_i & br_taken_i & ~jmp_i & ~ret_i;
  assign ev_seq = adv_i & ~(br_i & br_taken_i) & ~jmp_i & ~ret_i;

  always_comb begin
    src_o = SRC_HOLD;
    if (ev_ret)      src_o = SRC_RET;
    else if (ev_jmp) src_o = SRC_JMP;
    else if (ev_br)  src_o = SRC_BR;
    else if (ev_seq) src_o = SRC_SEQ;
  end

  assign commit_o = ev_ret | ev_jmp;

  // R7
  one_winner_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({ev_ret, ev_jmp, ev_br, ev_seq}));

  // R7
  ret_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ret_i |-> (src_o == SRC_RET));

endmodule

// File: rtl/pcs_pc_reg.sv
module pcs_pc_reg
  import pcs_pkg::*;
#(
  parameter int unsigned PC_W   = 12,
  parameter int unsigned PAGE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  pc_src_e           src_i,
  input  logic              len2_i,
  input  logic [PAGE_W-1:0] br_tgt_i,
  input  logic [PC_W-1:0]   jmp_tgt_i,
  input  logic [PC_W-1:0]   ret_val_i,
  output logic [PC_W-1:0]   pc_o
);

  logic [PC_W-1:0] pc_q, pc_d;
  logic [PC_W-1:0] seq_pc, br_pc;

  assign seq_pc = PC_W'(step_addr(32'(pc_q), len2_i, PC_W));
  assign br_pc  = PC_W'(page_join(32'(seq_pc), 32'(br_tgt_i), PAGE_W));

  always_comb begin
    unique case (src_i)
      SRC_SEQ: pc_d = seq_pc;
      SRC_BR:  pc_d = br_pc;
      SRC_JMP: pc_d = jmp_tgt_i;
      SRC_RET: pc_d = ret_val_i;
      default: pc_d = pc_q;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) pc_q <= '0;
    else        pc_q <= pc_d;
  end

  assign pc_o = pc_q;

  // R2
  seq_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (src_i == SRC_SEQ) |=>
      (PC_W'(pc_q - $past(pc_q)) == ($past(len2_i) ? PC_W'(2) : PC_W'(1))));

  // R3
  br_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (src_i == SRC_BR) |=> (pc_q[PAGE_W-1:0] == $past(br_tgt_i)));

  // R5
  jmp_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (src_i == SRC_JMP) |=> (pc_q == $past(jmp_tgt_i)));

  // R6
  ret_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (src_i == SRC_RET) |=> (pc_q == $past(ret_val_i)));

  // R11
  pc_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (src_i == SRC_HOLD) |=> $stable(pc_q));

endmodule

// File: rtl/pcs_bank_ctl.sv
module pcs_bank_ctl #(
  parameter int unsigned BANK_W = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bsel_i,
  input  logic [BANK_W-1:0] bsel_val_i,
  input  logic              commit_i,
  output logic [BANK_W-1:0] bank_o
);

  logic [BANK_W-1:0] pend_q, pend_d, bank_q;

  assign pend_d = bsel_i ? bsel_val_i : pend_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend_q <= '0;
      bank_q <= '0;
    end else begin
      pend_q <= pend_d;
      if (commit_i) bank_q <= pend_d;
    end
  end

  assign bank_o = bank_q;

  // R8
  pend_rec_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bsel_i |=> (pend_q == $past(bsel_val_i)));

  // R8
  bank_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !commit_i |=> $stable(bank_q));

  // R9
  bank_commit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    commit_i |=> (bank_q == pend_q));

endmodule

// File: rtl/banked_pc_seq.sv
module banked_pc_seq
  import pcs_pkg::*;
#(
  parameter int unsigned PC_W   = 12,
  parameter int unsigned PAGE_W = 8,
  parameter int unsigned BANK_W = 1,
  localparam int unsigned FA_W  = BANK_W + PC_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              adv_i,
  input  logic              len2_i,
  input  logic              br_i,
  input  logic              br_taken_i,
  input  logic [PAGE_W-1:0] br_tgt_i,
  input  logic              jmp_i,
  input  logic [PC_W-1:0]   jmp_tgt_i,
  input  logic              ret_i,
  input  logic [PC_W-1:0]   ret_val_i,
  input  logic              bsel_i,
  input  logic [BANK_W-1:0] bsel_val_i,
  output logic [FA_W-1:0]   fetch_addr_o,
  output logic [PC_W-1:0]   pc_o
);

  pc_src_e           src;
  logic              commit;
  logic [PC_W-1:0]   pc;
  logic [BANK_W-1:0] bank;

  pcs_next_sel u_sel (
    .clk        (clk),
    .rst_n      (rst_n),
    .adv_i      (adv_i),
    .br_i       (br_i),
    .br_taken_i (br_taken_i),
    .jmp_i      (jmp_i),
    .ret_i      (ret_i),
    .src_o      (src),
    .commit_o   (commit)
  );

  pcs_pc_reg #(.PC_W(PC_W), .PAGE_W(PAGE_W)) u_pc (
    .clk       (clk),
    .rst_n     (rst_n),
    .src_i     (src),
    .len2_i    (len2_i),
    .br_tgt_i  (br_tgt_i),
    .jmp_tgt_i (jmp_tgt_i),
    .ret_val_i (ret_val_i),
    .pc_o      (pc)
  );

  pcs_bank_ctl #(.BANK_W(BANK_W)) u_bank (
    .clk        (clk),
    .rst_n      (rst_n),
    .bsel_i     (bsel_i),
    .bsel_val_i (bsel_val_i),
    .commit_i   (commit),
    .bank_o     (bank)
  );

  assign fetch_addr_o = {bank, pc};
  assign pc_o         = pc;

  // R2
  wrap_keeps_bank_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (adv_i && !br_i && !jmp_i && !ret_i) |=>
      (fetch_addr_o[FA_W-1 -: BANK_W] == $past(fetch_addr_o[FA_W-1 -: BANK_W])));

endmodule

// File: tb/banked_pc_seq_tb.sv
module banked_pc_seq_tb;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        adv_i, len2_i, br_i, br_taken_i, jmp_i, ret_i, bsel_i, bsel_val_i;
  logic [7:0]  br_tgt_i;
  logic [11:0] jmp_tgt_i, ret_val_i;
  logic [12:0] fetch_addr_o;
  logic [11:0] pc_o;

  int n_chk = 0;
  int n_bad = 0;
  int m_pc, m_bank, m_pend;
  bit done = 0;

  always #2.5 clk = ~clk;

  banked_pc_seq u_dut (
    .clk(clk), .rst_n(rst_n), .adv_i(adv_i), .len2_i(len2_i),
    .br_i(br_i), .br_taken_i(br_taken_i), .br_tgt_i(br_tgt_i),
    .jmp_i(jmp_i), .jmp_tgt_i(jmp_tgt_i), .ret_i(ret_i), .ret_val_i(ret_val_i),
    .bsel_i(bsel_i), .bsel_val_i(bsel_val_i),
    .fetch_addr_o(fetch_addr_o), .pc_o(pc_o)
  );

  task automatic idle_in();
    adv_i = 0; len2_i = 0; br_i = 0; br_taken_i = 0; br_tgt_i = '0;
    jmp_i = 0; jmp_tgt_i = '0; ret_i = 0; ret_val_i = '0;
    bsel_i = 0; bsel_val_i = 0;
  endtask

  // Behavioural next-state rule applied to the driven inputs.
  task automatic model_step();
    int seq, nb;
    if (!rst_n) begin
      m_pc = 0; m_bank = 0; m_pend = 0;
      return;
    end
    seq = (m_pc + (len2_i ? 2 : 1)) % 4096;
    nb  = bsel_i ? int'(bsel_val_i) : m_pend;
    m_pend = nb;
    if (ret_i) begin
      m_pc = int'(ret_val_i); m_bank = nb;
    end else if (jmp_i) begin
      m_pc = int'(jmp_tgt_i); m_bank = nb;
    end else if (br_i && br_taken_i) begin
      m_pc = (seq / 256) * 256 + int'(br_tgt_i);
    end else if (adv_i) begin
      m_pc = seq;
    end
  endtask

  task automatic compare(string tag);
    int exp_fa;
    exp_fa = m_bank * 4096 + m_pc;
    n_chk++;
    if (int'(fetch_addr_o) != exp_fa) begin
      n_bad++;
      $display("FAIL %s/R10 fetch_addr_o actual %h expected %h", tag, fetch_addr_o, exp_fa);
    end
    n_chk++;
    if (int'(pc_o) != m_pc) begin
      n_bad++;
      $display("FAIL %s/R10 pc_o actual %h expected %h", tag, pc_o, m_pc);
    end
  endtask

  // One clock: inputs already driven; model follows the edge, compare at negedge.
  task automatic cyc(string tag);
    @(posedge clk);
    model_step();
    @(negedge clk);
    compare(tag);
    idle_in();
  endtask

  initial begin
    fork
      begin
        repeat (20000) @(posedge clk);
        if (!done) begin
          n_chk++; n_bad++;
          $display("FAIL watchdog expired");
          $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
          $finish;
        end
      end
    join_none
  end

  initial begin
    idle_in();
    rst_n = 0;
    m_pc = 0; m_bank = 0; m_pend = 0;
    // R1: inputs active during reset must not matter
    adv_i = 1; jmp_i = 1; jmp_tgt_i = 12'h5A5; bsel_i = 1; bsel_val_i = 1;
    cyc("R1");
    cyc("R1");
    rst_n = 1;
    cyc("R1");

    // R2: single and double steps
    adv_i = 1; cyc("R2");
    adv_i = 1; cyc("R2");
    adv_i = 1; len2_i = 1; cyc("R2");

    // R5 then R2 wrap
    jmp_i = 1; jmp_tgt_i = 12'hFFE; cyc("R5");
    adv_i = 1; len2_i = 1; cyc("R2");
    jmp_i = 1; jmp_tgt_i = 12'hFFF; cyc("R5");
    adv_i = 1; cyc("R2");

    // R3: branch at page end takes page of next byte
    jmp_i = 1; jmp_tgt_i = 12'h1FE; cyc("R5");
    br_i = 1; br_taken_i = 1; len2_i = 1; br_tgt_i = 8'h34; cyc("R3");
    br_i = 1; br_taken_i = 1; len2_i = 0; br_tgt_i = 8'hC7; cyc("R3");

    // R4: not taken
    br_i = 1; br_taken_i = 0; br_tgt_i = 8'h11; cyc("R4");
    br_i = 1; br_taken_i = 0; br_tgt_i = 8'h11; adv_i = 1; len2_i = 1; cyc("R4");

    // R11: idle
    cyc("R11"); cyc("R11");

    // R8: pending bank only
    bsel_i = 1; bsel_val_i = 1; cyc("R8");
    adv_i = 1; cyc("R8");
    br_i = 1; br_taken_i = 1; br_tgt_i = 8'h80; cyc("R8");
    // R9: jump commits bank 1
    jmp_i = 1; jmp_tgt_i = 12'h345; cyc("R9");
    // R6 + R9: return with same-cycle bank command
    ret_i = 1; ret_val_i = 12'hABC; bsel_i = 1; bsel_val_i = 0; cyc("R6");
    adv_i = 1; len2_i = 1; cyc("R9");

    // R7: overlaps
    ret_i = 1; ret_val_i = 12'h111; jmp_i = 1; jmp_tgt_i = 12'h222;
    br_i = 1; br_taken_i = 1; br_tgt_i = 8'h33; adv_i = 1; cyc("R7");
    jmp_i = 1; jmp_tgt_i = 12'h444; br_i = 1; br_taken_i = 1; br_tgt_i = 8'h55;
    adv_i = 1; cyc("R7");
    br_i = 1; br_taken_i = 1; br_tgt_i = 8'h66; adv_i = 1; len2_i = 1; cyc("R7");
    bsel_i = 1; bsel_val_i = 1; jmp_i = 1; jmp_tgt_i = 12'h777; adv_i = 1; cyc("R9");

    // Random mix of strobes
    for (int i = 0; i < 400; i++) begin
      adv_i      = $urandom_range(0, 1) == 1;
      len2_i     = $urandom_range(0, 1) == 1;
      br_i       = $urandom_range(0, 3) == 0;
      br_taken_i = $urandom_range(0, 1) == 1;
      br_tgt_i   = 8'($urandom);
      jmp_i      = $urandom_range(0, 7) == 0;
      jmp_tgt_i  = 12'($urandom);
      ret_i      = $urandom_range(0, 9) == 0;
      ret_val_i  = 12'($urandom);
      bsel_i     = $urandom_range(0, 5) == 0;
      bsel_val_i = $urandom_range(0, 1) == 1;
      cyc("R7");
    end

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

endmodule